// File: doc/BRIEF.md
# LED Breathing Envelope Sequencer

This block produces an 8-bit intensity value that makes an LED "breathe" without help from software. After a start it waits through an optional lead-in delay once. It then ramps the intensity linearly up to full scale, holds it, ramps it back down and keeps the LED dark. All five durations come from small log-encoded codes. Each code step doubles the time, counted in ticks of a base period. The base period is set by an internal prescaler whose clock-to-tick ratio is a parameter.

A hold-select input chooses where the sequence parks. With hold-select at 0 it parks at full intensity in the hold phase. With hold-select at 1 it parks dark in the off phase. Changing the select while parked releases the sequencer. From hold it then counts out the hold time and falls. From off it counts out the off time and starts a new rise.

When one-shot breathing is not selected, the intensity simply follows a direct duty input. A software-shutdown flag and an output-enable flag can blank the output at any time. The sequencer keeps its state while blanked. A restart edge, or leaving shutdown, starts the sequence again from the lead-in delay.

Top module: `breath_seq`

## Requirements
- R1: While reset is asserted, `level` is 0, `phase` is 0 (idle) and `busy` is 0.
- R2: With `oneshot_mode`=0, `out_en`=1 and `sw_shutdown`=0, `level` equals `duty_in` in the same cycle, and `phase` reads 0.
- R3: With `oneshot_mode`=1 and `ramp_en`=1, the sequencer leaves idle on the first clock edge and walks through the phases delay (1), rise (2), hold (3), fall (4) and off (5). With `oneshot_mode`=1 and `ramp_en`=0, `phase` stays 0 and `level` stays 0.
- R4: The sequencer moves only on base ticks, one every `TICK_DIV` clocks counted from a (re)start. The delay code `t0_code` and the off code `t4_code` are 4 bits wide. Code 0 means 0 ticks, code k from 1 to 10 means 2^(k-1) ticks, and codes 11 to 15 mean 512 ticks.
- R5: The rise code `t1_code` and the fall code `t3_code` are 3 bits wide, and code k lasts 2^k ticks (1 to 128). These phases are never zero.
- R6: The hold code `t2_code` is 4 bits wide. Code 0 means 0 ticks, code k from 1 to 8 means 2^(k-1) ticks, and codes 9 to 15 mean 128 ticks.
- R7: On the j-th tick of a rise lasting N ticks, `level` = j*256/N. On the j-th tick of a fall lasting N ticks, `level` = 255 - j*256/N. `level` is 255 in hold and 0 in delay and off.
- R8: A phase of zero length is skipped within the tick that would enter it. A zero delay starts directly in rise, and a zero hold with `hold_sel`=1 goes from rise straight to fall.
- R9: With `hold_sel`=0 the sequence parks in hold at 255. With `hold_sel`=1 it parks in off at 0. While parked, `busy` is 0. Changing `hold_sel` while parked resumes counting the parked phase: hold then goes to fall, and off goes to rise. A zero-length parked phase is left on the next tick.
- R10: While `sw_shutdown`=1, `level` is 0, `busy` is 0 and the phase and count are frozen. The edge after `sw_shutdown` returns to 0 restarts from delay.
- R11: `out_en`=0 forces `level` to 0 without disturbing the sequence.
- R12: A 0-to-1 change of `restart` restarts the sequence from delay. Keeping `restart` high does not restart it again.
- R13: In one-shot mode `duty_in` has no effect on `level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Restart request, acted on at its rising edge |
| oneshot_mode | input | 1 | 1 = automatic breathing, 0 = direct duty |
| ramp_en | input | 1 | Enables the breathing sequence in one-shot mode |
| hold_sel | input | 1 | 0 = park in hold, 1 = park in off |
| sw_shutdown | input | 1 | Blanks the output and freezes the sequence |
| out_en | input | 1 | Output enable |
| t0_code | input | 4 | Lead-in delay code |
| t1_code | input | 3 | Rise time code |
| t2_code | input | 4 | Hold time code |
| t3_code | input | 3 | Fall time code |
| t4_code | input | 4 | Off time code |
| duty_in | input | 8 | Direct intensity for non-breathing mode |
| level | output | 8 | Intensity envelope |
| phase | output | 3 | 0 idle, 1 delay, 2 rise, 3 hold, 4 fall, 5 off |
| busy | output | 1 | Sequence active and not parked |

## Verification
The bench sweeps the rise and fall codes against short delay and hold lengths and compares every tick with a timeline computed from cumulative durations. A ramp scaled by the wrong power of two, or a phase that runs one tick long or short, shows up as a level or phase mismatch at the first affected tick. Zero-length delay and hold, and out-of-range delay, hold and off codes, are run explicitly. A design that lingers for a tick in an empty phase, or that wraps an invalid code to a short time, therefore misses the expected phase boundary. Parking and release in both directions, a frozen shutdown followed by a restart, and a restart held high are checked tick by tick. These catch a counter that keeps running while parked and a restart that fires on level instead of on an edge.

// File: rtl/breath_seq.sv
module breath_seq #(
  parameter int TICK_DIV = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       oneshot_mode,
  input  logic       ramp_en,
  input  logic       hold_sel,
  input  logic       sw_shutdown,
  input  logic       out_en,
  input  logic [3:0] t0_code,
  input  logic [2:0] t1_code,
  input  logic [3:0] t2_code,
  input  logic [2:0] t3_code,
  input  logic [3:0] t4_code,
  input  logic [7:0] duty_in,
  output logic [7:0] level,
  output logic [2:0] phase,
  output logic       busy
);

  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int LONG_TICKS = 512;
  localparam int HOLD_TICKS = 128;
  localparam int CW = $clog2(LONG_TICKS) + 1;

  localparam logic [2:0] PH_IDLE  = 3'd0;
  localparam logic [2:0] PH_DELAY = 3'd1;
  localparam logic [2:0] PH_RISE  = 3'd2;
  localparam logic [2:0] PH_HOLD  = 3'd3;
  localparam logic [2:0] PH_FALL  = 3'd4;
  localparam logic [2:0] PH_OFF   = 3'd5;

  function automatic logic [CW-1:0] span_long(input logic [3:0] c);
    if (c == 4'd0)       return '0;
    else if (c > 4'd10)  return CW'(LONG_TICKS);
    else                 return CW'(1) << (c - 4'd1);
  endfunction

  function automatic logic [CW-1:0] span_ramp(input logic [2:0] c);
    return CW'(1) << c;
  endfunction

  function automatic logic [CW-1:0] span_hold(input logic [3:0] c);
    if (c == 4'd0)      return '0;
    else if (c > 4'd8)  return CW'(HOLD_TICKS);
    else                return CW'(1) << (c - 4'd1);
  endfunction

  logic [PW-1:0] pre;
  logic [CW-1:0] cnt, cur_span;
  logic [2:0]    ph, succ, nxt, first_ph;
  logic          restart_q, shd_q;
  logic          active, tick, start_evt, parked;
  logic [CW+7:0] up_full, dn_full;
  logic [7:0]    up_lvl, dn_lvl, env;

  assign active    = oneshot_mode & ramp_en;
  assign tick      = (pre == PW'(TICK_DIV - 1));
  assign start_evt = active & ((ph == PH_IDLE) | (restart & ~restart_q) | (shd_q & ~sw_shutdown));
  assign parked    = ((ph == PH_HOLD) & ~hold_sel) | ((ph == PH_OFF) & hold_sel);
  assign first_ph  = (t0_code == 4'd0) ? PH_RISE : PH_DELAY;

  always_comb begin
    case (ph)
      PH_DELAY: cur_span = span_long(t0_code);
      PH_RISE:  cur_span = span_ramp(t1_code);
      PH_HOLD:  cur_span = span_hold(t2_code);
      PH_FALL:  cur_span = span_ramp(t3_code);
      PH_OFF:   cur_span = span_long(t4_code);
      default:  cur_span = '0;
    endcase
  end

  always_comb begin
    case (ph)
      PH_DELAY: succ = PH_RISE;
      PH_RISE:  succ = PH_HOLD;
      PH_HOLD:  succ = PH_FALL;
      PH_FALL:  succ = PH_OFF;
      default:  succ = PH_RISE;
    endcase
    nxt = succ;
    if (succ == PH_HOLD && hold_sel && t2_code == 4'd0) nxt = PH_FALL;
    if (succ == PH_OFF && !hold_sel && t4_code == 4'd0) nxt = PH_RISE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre       <= '0;
      cnt       <= '0;
      ph        <= PH_IDLE;
      restart_q <= 1'b0;
      shd_q     <= 1'b0;
    end else begin
      restart_q <= restart;
      shd_q     <= sw_shutdown;
      if (!active) begin
        ph  <= PH_IDLE;
        cnt <= '0;
        pre <= '0;
      end else if (start_evt) begin
        ph  <= first_ph;
        cnt <= '0;
        pre <= '0;
      end else if (!sw_shutdown) begin
        pre <= tick ? '0 : pre + PW'(1);
        if (tick && !parked) begin
          if (cnt + CW'(1) >= cur_span) begin
            ph  <= nxt;
            cnt <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
      end
    end
  end

  assign up_full = {cnt, 8'h00} >> t1_code;
  assign dn_full = {cnt, 8'h00} >> t3_code;
  assign up_lvl  = up_full[7:0];
  assign dn_lvl  = ~dn_full[7:0];

  always_comb begin
    case (ph)
      PH_RISE: env = up_lvl;
      PH_HOLD: env = 8'hFF;
      PH_FALL: env = dn_lvl;
      default: env = 8'h00;
    endcase
  end

  assign level = (sw_shutdown | ~out_en) ? 8'h00 : (oneshot_mode ? env : duty_in);
  assign phase = ph;
  assign busy  = active & ~sw_shutdown & (ph != PH_IDLE) & ~parked;

  // R10
  shutdown_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && sw_shutdown && !start_evt) |=> ($stable(ph) && $stable(cnt)));

  // R4
  tick_only_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start_evt && !tick) |=> $stable(ph));

  // R9
  hold_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start_evt && ph == PH_HOLD && !hold_sel) |=> (ph == PH_HOLD));

  // R9
  off_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !start_evt && ph == PH_OFF && hold_sel) |=> (ph == PH_OFF));

  // R5
  fall_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_FALL && $past(ph) != PH_FALL) |-> ($past(ph) == PH_RISE || $past(ph) == PH_HOLD));

  // R7
  rise_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_RISE && active && !start_evt) |=>
      ((ph != PH_RISE) || !$stable(t1_code) || (up_lvl >= $past(up_lvl))));

endmodule

// File: tb/sim_breath_seq.sv
module sim_breath_seq;
  localparam int DIV = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       restart = 1'b0;
  logic       oneshot_mode = 1'b1;
  logic       ramp_en = 1'b1;
  logic       hold_sel = 1'b1;
  logic       sw_shutdown = 1'b0;
  logic       out_en = 1'b1;
  logic [3:0] t0_code = 4'd0;
  logic [2:0] t1_code = 3'd0;
  logic [3:0] t2_code = 4'd0;
  logic [2:0] t3_code = 3'd0;
  logic [3:0] t4_code = 4'd0;
  logic [7:0] duty_in = 8'h99;
  logic [7:0] level;
  logic [2:0] phase;
  logic       busy;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  always #2 clk = ~clk;

  breath_seq #(.TICK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .restart(restart), .oneshot_mode(oneshot_mode),
    .ramp_en(ramp_en), .hold_sel(hold_sel), .sw_shutdown(sw_shutdown), .out_en(out_en),
    .t0_code(t0_code), .t1_code(t1_code), .t2_code(t2_code), .t3_code(t3_code),
    .t4_code(t4_code), .duty_in(duty_in), .level(level), .phase(phase), .busy(busy)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nerr++;
      nchk++;
      $display("FAIL R4 watchdog act=%0d cycles exp=fewer", cyc);
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  function automatic int d_long(input int c);
    if (c == 0) return 0;
    if (c > 10) return 512;
    return 1 << (c - 1);
  endfunction

  function automatic int d_ramp(input int c);
    return 1 << c;
  endfunction

  function automatic int d_hold(input int c);
    if (c == 0) return 0;
    if (c > 8) return 128;
    return 1 << (c - 1);
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic void exp_at(input int k, output int ep, output int el, output int eb);
    int a, b, c, d, n1, n3;
    n1 = d_ramp(int'(t1_code));
    n3 = d_ramp(int'(t3_code));
    a = d_long(int'(t0_code));
    b = a + n1;
    c = b + d_hold(int'(t2_code));
    d = c + n3;
    if (k < a)            begin ep = 1; el = 0; eb = 1; end
    else if (k < b)       begin ep = 2; el = (k - a) * 256 / n1; eb = 1; end
    else if (!hold_sel)   begin ep = 3; el = 255; eb = 0; end
    else if (k < c)       begin ep = 3; el = 255; eb = 1; end
    else if (k < d)       begin ep = 4; el = 255 - (k - c) * 256 / n3; eb = 1; end
    else                  begin ep = 5; el = 0; eb = 0; end
  endfunction

  task automatic chk3(input string tag, input int ep, input int el, input int eb);
    chk(tag, "phase", int'(phase), ep);
    chk(tag, "level", int'(level), el);
    chk(tag, "busy", int'(busy), eb);
  endtask

  task automatic walk(input string tag, input int k0, input int k1);
    int ep, el, eb;
    for (int k = k0; k <= k1; k++) begin
      if (k > k0) repeat (DIV) @(negedge clk);
      exp_at(k, ep, el, eb);
      chk3(tag, ep, el, eb);
    end
  endtask

  task automatic restart_pulse();
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
  endtask

  task automatic set_codes(input int a, input int b, input int c, input int d, input int e, input logic hs);
    t0_code = 4'(a); t1_code = 3'(b); t2_code = 4'(c); t3_code = 3'(d); t4_code = 4'(e);
    hold_sel = hs;
  endtask

  function automatic int run_len();
    return d_long(int'(t0_code)) + d_ramp(int'(t1_code)) + d_hold(int'(t2_code)) + d_ramp(int'(t3_code));
  endfunction

  // R9: leave hold park; rise and fall codes 1 (2 ticks)
  task automatic hold_release(input int c2);
    int eff;
    set_codes(0, 1, c2, 1, 0, 1'b0);
    restart_pulse();
    walk("R9", 0, 4);
    hold_sel = 1'b1;
    eff = (d_hold(c2) > 1) ? d_hold(c2) : 1;
    for (int j = 1; j <= eff + 2; j++) begin
      repeat (DIV) @(negedge clk);
      if (j < eff)           chk3("R9", 3, 255, 1);
      else if (j == eff)     chk3("R9", 4, 255, 1);
      else if (j == eff + 1) chk3("R9", 4, 127, 1);
      else                   chk3("R9", 5, 0, 0);
    end
  endtask

  // R9: leave off park (must follow hold_release)
  task automatic off_release(input int c4);
    int eff;
    t4_code = 4'(c4);
    hold_sel = 1'b0;
    eff = (d_long(c4) > 1) ? d_long(c4) : 1;
    for (int j = 1; j <= eff + 2; j++) begin
      repeat (DIV) @(negedge clk);
      if (j < eff)           chk3("R4", 5, 0, 1);
      else if (j == eff)     chk3("R9", 2, 0, 1);
      else if (j == eff + 1) chk3("R9", 2, 128, 1);
      else                   chk3("R9", 3, 255, 0);
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk3("R1", 0, 0, 0);
    ramp_en = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R3: one-shot without ramp enable stays idle
    chk3("R3", 0, 0, 0);

    // R2: direct duty, exhaustive
    oneshot_mode = 1'b0;
    for (int d = 0; d < 256; d++) begin
      duty_in = 8'(d);
      @(negedge clk);
      chk("R2", "level", int'(level), d);
      chk("R2", "phase", int'(phase), 0);
    end
    duty_in = 8'h5A;
    sw_shutdown = 1'b1;
    @(negedge clk) chk("R10", "pwm level", int'(level), 0);
    sw_shutdown = 1'b0;
    out_en = 1'b0;
    @(negedge clk) chk("R11", "pwm level", int'(level), 0);
    out_en = 1'b1;

    // R3: activation from idle starts the sequence
    oneshot_mode = 1'b1;
    duty_in = 8'hC3;
    set_codes(1, 1, 1, 1, 0, 1'b1);
    @(negedge clk) ramp_en = 1'b1;
    @(negedge clk);
    walk("R3", 0, run_len() + 2);

    // R5 R7 R8 R13: sweep rise/fall codes with short delay and hold
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int z = 0; z < 2; z++)
          for (int h = 0; h < 3; h++) begin
            set_codes(z, a, h, b, 0, 1'b1);
            restart_pulse();
            walk("R7", 0, run_len() + 2);
          end

    // R9: park in hold
    for (int a = 0; a < 4; a++) begin
      set_codes(3, a, 2, 1, 0, 1'b0);
      restart_pulse();
      walk("R9", 0, d_long(3) + d_ramp(a) + 3);
    end

    // R8: zero delay and zero hold
    set_codes(0, 1, 0, 1, 0, 1'b1);
    restart_pulse();
    walk("R8", 0, 6);

    // R4 R5 R6: longest legal codes
    set_codes(10, 7, 8, 7, 0, 1'b1);
    restart_pulse();
    walk("R4", 0, run_len() + 2);

    // R4 R6: invalid codes saturate
    set_codes(13, 0, 11, 0, 0, 1'b1);
    restart_pulse();
    walk("R6", 0, run_len() + 2);

    // R9 R4 R6: release from both parks
    hold_release(0);
    off_release(0);
    hold_release(2);
    off_release(3);
    hold_release(12);
    off_release(14);

    // R11 R13: blanking and ignored duty while parked in hold
    set_codes(0, 0, 1, 0, 0, 1'b0);
    restart_pulse();
    walk("R9", 0, 2);
    duty_in = 8'h3C;
    @(negedge clk) chk("R13", "level", int'(level), 255);
    out_en = 1'b0;
    @(negedge clk) chk("R11", "level", int'(level), 0);
    repeat (3 * DIV) @(negedge clk);
    chk("R11", "phase", int'(phase), 3);
    out_en = 1'b1;
    @(negedge clk) chk("R11", "level", int'(level), 255);

    // R10: shutdown freezes, leaving restarts
    set_codes(2, 2, 1, 2, 0, 1'b1);
    restart_pulse();
    walk("R7", 0, 3);
    sw_shutdown = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk3("R10", 2, 0, 0);
    end
    sw_shutdown = 1'b0;
    @(negedge clk);
    walk("R10", 0, run_len() + 2);

    // R12: mid-run restart
    set_codes(1, 2, 1, 1, 0, 1'b1);
    restart_pulse();
    walk("R12", 0, 3);
    restart_pulse();
    walk("R12", 0, run_len() + 2);

    // R12: restart held high fires once
    set_codes(1, 1, 1, 1, 0, 1'b1);
    @(negedge clk) restart = 1'b1;
    @(negedge clk);
    walk("R12", 0, run_len() + 3);
    restart = 1'b0;
    @(negedge clk) chk3("R12", 5, 0, 0);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule